// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block converts parallel characters into asynchronous serial frames on a single output line. Bit timing comes from an enable pulse that runs at sixteen times the baud rate, so every bit lasts sixteen enable pulses. The baud divider that produces this pulse is outside the block. Characters wait in a buffer until the shift engine takes them. With buffering enabled, the buffer holds sixteen entries. With buffering disabled, it holds a single entry, so one character can wait while another is being shifted out.

Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a stop period at the high level. The frame settings are captured when a character is loaded, so a frame in flight keeps its shape. A break control holds the line low. An optional flow-control mode makes a clear-to-send input gate the start of each character. Two status outputs report whether the buffer is empty and whether the whole transmitter is empty.

Top module: `ser_tx`

## Requirements
- R1: While reset is held and immediately after it, `txd_o` is 1, `hold_empty_o` is 1 and `tx_empty_o` is 1.
- R2: A loaded character produces a start bit at level 0 and then the data bits, least significant bit first. Each bit lasts exactly 16 pulses of `tick16_i`. The start bit begins in the cycle after the load.
- R3: `char_len_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Higher data bits of the written byte are not sent.
- R4: When `par_en_i` is 1, a parity bit follows the data bits. With `par_odd_i` = 0 it makes the count of ones over data and parity even. With `par_odd_i` = 1 it makes that count odd. When `par_en_i` is 0, no parity bit is sent.
- R5: The stop period is high. With `stop_long_i` = 0 it lasts 16 ticks. With `stop_long_i` = 1 it lasts 24 ticks (1.5 bits) for 5-bit characters and 32 ticks (2 bits) for longer characters.
- R6: With `fifo_en_i` = 1, the buffer accepts up to 16 characters. A write while 16 are waiting is dropped.
- R7: With `fifo_en_i` = 0, the buffer holds one character. A write while it is occupied is dropped. Characters are sent in write order, with one idle-level cycle between frames.
- R8: While `brk_i` is 1, `txd_o` is 0. Frame timing runs on underneath, so the remaining bits appear unchanged once `brk_i` clears.
- R9: With `auto_cts_i` = 1 and `cts_i` = 0, no new character starts. A character already started completes. When `auto_cts_i` = 0, `cts_i` has no effect.
- R10: `hold_empty_o` is 1 exactly when no character waits in the buffer. `tx_empty_o` is 1 exactly when the buffer is empty and no frame is in progress. The idle line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the baud rate |
| wr_en_i | input | 1 | Write a character into the buffer |
| wr_data_i | input | 8 | Character to write |
| fifo_en_i | input | 1 | 1: 16-entry buffer, 0: single holding entry |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop_long_i | input | 1 | 1: 1.5 or 2 stop bits, 0: one stop bit |
| brk_i | input | 1 | Force the line low |
| auto_cts_i | input | 1 | Gate character starts with `cts_i` |
| cts_i | input | 1 | Clear to send, active high |
| txd_o | output | 1 | Serial output |
| hold_empty_o | output | 1 | Buffer empty |
| tx_empty_o | output | 1 | Buffer and shifter both empty |

## Verification
A wrong tick counter or bit index shows up on `txd_o` as a bit edge that arrives early or late. The bench catches this at the first sample after the expected edge, which is within one bit period of the fault. A wrong buffer count or pointer shows up later: a character goes missing, repeats or comes out of order, and the status outputs change at the wrong cycle. Because the reference model compares every output on every cycle, each of these faults is reported in the first cycle it reaches a port. A wrong flow-control decision shows up as a start bit during a blocked interval, or as a frame cut short when `cts_i` drops.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] limit_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // admission judged on the count before any same-cycle pop
  assign do_push = push_i && (count_q < limit_i);
  assign do_pop  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign data_o  = mem[rptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  localparam int MINB   = DW - 3,
  localparam int IW     = $clog2(DW),
  localparam int TW     = $clog2(2 * OVS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    char_len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop_long_i,
  output logic          busy_o,
  output logic          line_o
);
  tx_state_e     state_q;
  logic [TW-1:0] tcnt_q, stop_q, lim;
  logic [IW-1:0] bidx_q, last_q;
  logic [DW-1:0] shreg_q, mask;
  logic          par_q, par_en_q, bit_done;
  logic [TW-1:0] stop_sel;

  assign mask     = {DW{1'b1}} >> (2'd3 - char_len_i);
  assign stop_sel = !stop_long_i        ? TW'(OVS) :
                    (char_len_i == 2'd0) ? TW'(OVS + OVS / 2) : TW'(2 * OVS);
  assign lim      = (state_q == ST_STOP) ? stop_q : TW'(OVS);
  assign bit_done = (tcnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      last_q   <= '0;
      shreg_q  <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      stop_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (load_i) begin
        shreg_q  <= data_i;
        par_q    <= (^(data_i & mask)) ^ par_odd_i;
        par_en_q <= par_en_i;
        last_q   <= IW'(MINB - 1) + IW'(char_len_i);
        stop_q   <= stop_sel;
        tcnt_q   <= '0;
        bidx_q   <= '0;
        state_q  <= ST_START;
      end
    end else if (tick_i) begin
      if (!bit_done) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (bidx_q == last_q) state_q <= par_en_q ? ST_PAR : ST_STOP;
            else                  bidx_q  <= bidx_q + 1'b1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          fifo_en_i,
  input  logic [1:0]    char_len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop_long_i,
  input  logic          brk_i,
  input  logic          auto_cts_i,
  input  logic          cts_i,
  output logic          txd_o,
  output logic          hold_empty_o,
  output logic          tx_empty_o
);
  logic [CW-1:0] limit, fifo_count;
  logic [DW-1:0] head;
  logic          busy, line, load, cts_ok;

  assign limit  = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign cts_ok = !auto_cts_i || cts_i;
  assign load   = !busy && (fifo_count != '0) && cts_ok;

  ser_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .pop_i   (load),
    .data_i  (wr_data_i),
    .limit_i (limit),
    .data_o  (head),
    .count_o (fifo_count)
  );

  ser_tx_frame #(.DW(DW), .OVS(OVS)) u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .load_i      (load),
    .data_i      (head),
    .char_len_i  (char_len_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .stop_long_i (stop_long_i),
    .busy_o      (busy),
    .line_o      (line)
  );

  assign txd_o        = line && !brk_i;
  assign hold_empty_o = (fifo_count == '0);
  assign tx_empty_o   = hold_empty_o && !busy;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          brk_i,
  input logic          auto_cts_i,
  input logic          cts_i,
  input logic          txd_o,
  input logic          hold_empty_o,
  input logic          tx_empty_o,
  input logic          busy_i,
  input logic [CW-1:0] count_i,
  input logic [CW-1:0] limit_i
);
  AST_BRK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o); // R8

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !brk_i) |-> !txd_o); // R2

  AST_CTS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!auto_cts_i || cts_i)); // R9

  AST_EMPTY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_empty_o |-> !tx_empty_o); // R10

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH)); // R6

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == limit_i) |=> (count_i <= $past(count_i))); // R7
endmodule

bind ser_tx ser_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .brk_i        (brk_i),
  .auto_cts_i   (auto_cts_i),
  .cts_i        (cts_i),
  .txd_o        (txd_o),
  .hold_empty_o (hold_empty_o),
  .tx_empty_o   (tx_empty_o),
  .busy_i       (busy),
  .count_i      (fifo_count),
  .limit_i      (limit)
);

// File: tb/ser_tx_bench.sv
`timescale 1ns/1ps
module ser_tx_bench;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       wr_en = 1'b0, fifo_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic       stop_long = 1'b0, brk = 1'b0, auto_cts = 1'b0, cts = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] char_len = 2'd3;
  logic       txd, hold_empty, tx_empty;

  int    checks = 0, fails = 0, cyc = 0, tdiv = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0]  q[$];
  bit          busy_m = 0;
  int          pos_m = 0, total_m = 0, nfb = 0;
  logic [11:0] fbits = '1;

  always #2 clk = ~clk;

  ser_tx u_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_en_i(fifo_en), .char_len_i(char_len), .par_en_i(par_en), .par_odd_i(par_odd),
    .stop_long_i(stop_long), .brk_i(brk), .auto_cts_i(auto_cts), .cts_i(cts),
    .txd_o(txd), .hold_empty_o(hold_empty), .tx_empty_o(tx_empty)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  // 16x enable every third clock
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 3;
    tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
      summary();
      $finish;
    end
  end

  // behavioural model, evaluated on the pre-edge input values
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      busy_m = 0;
      pos_m  = 0;
    end else begin
      bit         pop, push;
      int         n, stp;
      logic [7:0] d;
      pop  = !busy_m && (q.size() > 0) && (!auto_cts || cts);
      push = wr_en && (q.size() < (fifo_en ? 16 : 1));
      if (busy_m && tick) begin
        if (pos_m == total_m - 1) busy_m = 0;
        else pos_m++;
      end
      if (pop) begin
        d = q.pop_front();
        n = 5 + int'(char_len);
        fbits = '1;
        fbits[0] = 1'b0;
        for (int i = 0; i < n; i++) fbits[1+i] = d[i];
        nfb = 1 + n;
        if (par_en) begin
          logic p;
          p = par_odd;
          for (int i = 0; i < n; i++) p ^= d[i];
          fbits[nfb] = p;
          nfb++;
        end
        stp = !stop_long ? 16 : (n == 5 ? 24 : 32);
        total_m = 16 * nfb + stp;
        busy_m = 1;
        pos_m = 0;
      end
      if (push) q.push_back(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_txd;
      if (brk) exp_txd = 1'b0;
      else if (!busy_m) exp_txd = 1'b1;
      else if (pos_m / 16 < nfb) exp_txd = fbits[pos_m/16];
      else exp_txd = 1'b1;
      check(cur_req, "txd_o", txd, exp_txd);
      check("R10", "hold_empty_o", hold_empty, q.size() == 0);
      check("R10", "tx_empty_o", tx_empty, (q.size() == 0) && !busy_m);
    end
  end

  task automatic burst(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b1;
      wr_data = 8'(seed + i * 37);
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (!(q.size() == 0 && !busy_m)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] len, input logic pe, input logic po, input logic sl);
    @(posedge clk); #1;
    char_len = len; par_en = pe; par_odd = po; stop_long = sl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "txd_o in reset", txd, 1'b1);
    check("R1", "hold_empty_o in reset", hold_empty, 1'b1);
    check("R1", "tx_empty_o in reset", tx_empty, 1'b1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R2";
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    burst(3, 8'h35);
    wait_done();

    cur_req = "R3";
    for (int l = 0; l < 3; l++) begin
      cfg(2'(l), 1'b0, 1'b0, 1'b0);
      burst(2, 8'hE7 + l);
      wait_done();
    end

    cur_req = "R5";
    for (int l = 0; l < 4; l++) begin
      cfg(2'(l), 1'b0, 1'b0, 1'b1);
      burst(2, 8'h5A + l);
      wait_done();
    end

    cur_req = "R4";
    cfg(2'd2, 1'b1, 1'b0, 1'b0);
    burst(4, 8'h13);
    wait_done();
    cfg(2'd3, 1'b1, 1'b1, 1'b1);
    burst(4, 8'hC1);
    wait_done();
    cfg(2'd0, 1'b1, 1'b1, 1'b1);
    burst(3, 8'h0F);
    wait_done();

    cur_req = "R6";
    cfg(2'd0, 1'b0, 1'b0, 1'b0);
    burst(22, 8'h41);
    wait_done();

    cur_req = "R7";
    @(posedge clk); #1 fifo_en = 1'b0;
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    burst(5, 8'h99);
    wait_done();
    burst(1, 8'h21);
    repeat (60) @(negedge clk);
    burst(1, 8'h66);
    wait_done();
    @(posedge clk); #1 fifo_en = 1'b1;

    cur_req = "R8";
    @(posedge clk); #1 brk = 1'b1;
    repeat (30) @(negedge clk);
    @(posedge clk); #1 brk = 1'b0;
    burst(1, 8'hA5);
    repeat (70) @(negedge clk);
    @(posedge clk); #1 brk = 1'b1;
    repeat (120) @(negedge clk);
    @(posedge clk); #1 brk = 1'b0;
    wait_done();

    cur_req = "R9";
    @(posedge clk); #1 begin auto_cts = 1'b1; cts = 1'b0; end
    burst(2, 8'h3C);
    repeat (200) @(negedge clk);
    @(posedge clk); #1 cts = 1'b1;
    repeat (100) @(negedge clk);
    @(posedge clk); #1 cts = 1'b0;
    repeat (900) @(negedge clk);
    @(posedge clk); #1 cts = 1'b1;
    wait_done();
    @(posedge clk); #1 begin auto_cts = 1'b0; cts = 1'b0; end
    burst(2, 8'h77);
    wait_done();

    cur_req = "R10";
    burst(1, 8'h81);
    wait_done();

    summary();
    $finish;
  end
endmodule